// File: doc/BRIEF.md
# Harmonic-Safe Delay Code Controller

This block drives the delay setting of an all-digital delay-locked loop. It takes the reference clock, an active-low reset and a single compare bit from a rising-edge phase detector. High on that bit means the loop needs more delay. The controller keeps a 10-bit delay code. The upper half selects how many coarse delay elements are active and the lower half selects the fine trim. Each half is also sent out as a 32-bit thermometer word and its bitwise complement, ready to drive the two delay lines.

Locking runs in three phases, and each phase starts only after the previous one ends. The first phase steps the coarse code upward through eight evenly spaced intervals, one interval per 4 clocks. Because each step is small, the loop never jumps far enough to settle on a multiple of the clock period. The second phase steps back one interval and runs a successive-approximation search over the seven low code bits, one bit per 8 clocks. The third phase turns the same register into a saturating up/down counter that follows slow drift.

The lock flag rises when the third phase starts. In the worst case this happens 88 clocks after reset is released. All pins are plain control and status signals: there is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `dll_code_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the code is 64, the phase indication is 0 (interval stepping) and the lock flag is low. The phase encoding is 0 for interval stepping, 1 for binary search and 2 for tracking.
- R2: The coarse thermometer word has ones in exactly its lowest N bit positions, where N is code bits [9:5]. The fine word is built the same way from code bits [4:0]. Each complement output is the bitwise inverse of its word.
- R3: At the first update after reset (the 4th rising edge), the code becomes 128 whatever the compare bit is.
- R4: During interval stepping the code changes only on every 4th rising edge. From code 128 onward, a high compare at an update adds 128, up to a top interval of 896. Code bits [6:0] stay zero, except in the first interval (code 64).
- R5: Interval stepping ends at an update where the compare bit is low. The search then starts at the interval below the current code, with bit 6 set (current code minus 64). If the compare bit is high at code 896, the search starts at 960 instead.
- R6: Binary search updates once every 8 rising edges and resolves bits 6 down to 0 in that order. At each update the bit under trial is kept if compare is high and cleared if it is low, and the next lower bit is set for trial.
- R7: After the seventh search update the phase becomes tracking and the lock flag rises. This happens no later than the 88th rising edge after reset release.
- R8: In tracking, each update (every 8 edges) moves the code by one step: up on high compare, down on low compare. The code holds at 1023 and at 0 instead of wrapping.
- R9: Once raised, the lock flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Phase compare result, high = more delay needed |
| code_o | output | 10 | Current delay code |
| crs_therm_o | output | 32 | Coarse thermometer word from code[9:5] |
| crs_therm_n_o | output | 32 | Complement of the coarse word |
| fin_therm_o | output | 32 | Fine thermometer word from code[4:0] |
| fin_therm_n_o | output | 32 | Complement of the fine word |
| mode_o | output | 2 | Phase: 0 interval, 1 search, 2 tracking |
| locked_o | output | 1 | Lock flag, sticky until reset |

## Verification
A fault in the update divider shows up as a code change on the wrong edge. This is visible within the first 4 or 8 edges, because the bench samples the edge just before each expected update as well as the update edge itself. A fault in the interval-to-search handoff leaves a wrong base value, which shows at the port as a wrong starting code on the exit edge. A fault in the bit-trial logic shows as a lock code that differs from the bench's target. The bench drives its compare bit from an ideal target model, so a correct search lands exactly on the target. A wrong lock count or a counter that wraps shows at most one tracking update after it happens.

// File: rtl/dllc_pkg.sv
package dllc_pkg;
  typedef enum logic [1:0] {
    MD_IVL = 2'd0,
    MD_SAR = 2'd1,
    MD_TRK = 2'd2
  } dllc_mode_e;
endpackage

// File: rtl/dllc_tick.sv
// Update strobe: one pulse per period, period chosen by the current phase.
module dllc_tick #(
  parameter int IVL_DIV = 4,
  parameter int SAR_DIV = 8,
  parameter int TRK_DIV = 8,
  localparam int MAX_DIV = (IVL_DIV > SAR_DIV) ? ((IVL_DIV > TRK_DIV) ? IVL_DIV : TRK_DIV)
                                               : ((SAR_DIV > TRK_DIV) ? SAR_DIV : TRK_DIV),
  localparam int DIV_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dllc_pkg::dllc_mode_e mode_i,
  output logic                 tick_o
);
  import dllc_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_w;

  always_comb begin
    unique case (mode_i)
      MD_IVL:  last_w = DIV_W'(IVL_DIV - 1);
      MD_SAR:  last_w = DIV_W'(SAR_DIV - 1);
      default: last_w = DIV_W'(TRK_DIV - 1);
    endcase
  end

  assign tick_o = (div_q == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R6: search strobes are never back to back
  a_r6_sar_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_SAR && tick_o) |=> !tick_o);
endmodule

// File: rtl/dllc_therm.sv
// Binary to thermometer expansion with complement.
module dllc_therm #(
  parameter int IN_W = 5,
  localparam int OUT_W = 1 << IN_W
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] therm_o,
  output logic [OUT_W-1:0] therm_n_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign therm_o[i]   = (val_i > IN_W'(i));
    assign therm_n_o[i] = ~therm_o[i];
  end
endmodule

// File: rtl/dllc_seq.sv
// Three-phase code sequencer: interval stepping, binary search, tracking.
module dllc_seq #(
  parameter int CODE_W   = 10,
  parameter int IVL_BITS = 3,
  localparam int SRCH_W  = CODE_W - IVL_BITS,
  localparam int SB_W    = $clog2(SRCH_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 cmp_i,
  output logic [CODE_W-1:0]    code_o,
  output dllc_pkg::dllc_mode_e mode_o,
  output logic                 locked_o
);
  import dllc_pkg::*;

  localparam logic [CODE_W-1:0] FIRST    = CODE_W'(1) << (SRCH_W - 1);
  localparam logic [CODE_W-1:0] IVL_STEP = CODE_W'(1) << SRCH_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  dllc_mode_e        mode_q, mode_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [SB_W-1:0]   bit_q, bit_n;
  logic              first_q, first_n;
  logic              locked_q, locked_n;
  logic              top_ivl_w;
  logic [CODE_W-1:0] base_w;

  assign top_ivl_w = &code_q[CODE_W-1 -: IVL_BITS];
  assign base_w    = cmp_i ? code_q : (code_q - IVL_STEP);

  always_comb begin
    mode_n   = mode_q;
    code_n   = code_q;
    bit_n    = bit_q;
    first_n  = first_q;
    locked_n = locked_q;
    if (tick_i) begin
      unique case (mode_q)
        MD_IVL: begin
          if (first_q) begin
            code_n  = IVL_STEP;
            first_n = 1'b0;
          end else if (cmp_i && !top_ivl_w) begin
            code_n = code_q + IVL_STEP;
          end else begin
            mode_n = MD_SAR;
            code_n = base_w | FIRST;
            bit_n  = SB_W'(SRCH_W - 1);
          end
        end
        MD_SAR: begin
          if (!cmp_i) code_n[bit_q] = 1'b0;
          if (bit_q == '0) begin
            mode_n   = MD_TRK;
            locked_n = 1'b1;
          end else begin
            code_n[bit_q - 1'b1] = 1'b1;
            bit_n = bit_q - 1'b1;
          end
        end
        default: begin
          if (cmp_i && code_q != CODE_MAX)  code_n = code_q + 1'b1;
          else if (!cmp_i && code_q != '0)  code_n = code_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_IVL;
      code_q   <= FIRST;
      bit_q    <= '0;
      first_q  <= 1'b1;
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      code_q   <= code_n;
      bit_q    <= bit_n;
      first_q  <= first_n;
      locked_q <= locked_n;
    end
  end

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign locked_o = locked_q;

  // R4: interval phase keeps the low search bits clear outside the first interval
  a_r4_ivl_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_IVL) |-> (code_q[SRCH_W-1:0] == '0 || code_q == FIRST));
  // R6: the code moves only on an update strobe
  a_r6_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(code_q));
  // R7: lock flag and tracking phase agree
  a_r7_lock_mode: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (mode_q == MD_TRK));
  // R8: tracking moves by at most one step, no wrap
  a_r8_track_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TRK) |=> (code_q == $past(code_q) || 32'(code_q) == 32'($past(code_q)) + 1
                            || 32'(code_q) + 1 == 32'($past(code_q))));
  // R8: tracking is the final phase
  a_r8_track_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TRK) |=> (mode_q == MD_TRK));
  // R9: lock is sticky
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl #(
  parameter int HALF_W   = 5,
  parameter int IVL_BITS = 3,
  parameter int IVL_DIV  = 4,
  parameter int SAR_DIV  = 8,
  parameter int TRK_DIV  = 8,
  localparam int CODE_W  = 2 * HALF_W,
  localparam int THERM_W = 1 << HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [THERM_W-1:0] crs_therm_o,
  output logic [THERM_W-1:0] crs_therm_n_o,
  output logic [THERM_W-1:0] fin_therm_o,
  output logic [THERM_W-1:0] fin_therm_n_o,
  output logic [1:0]         mode_o,
  output logic               locked_o
);
  import dllc_pkg::*;

  dllc_mode_e        mode_w;
  logic              tick_w;
  logic [CODE_W-1:0] code_w;

  dllc_tick #(.IVL_DIV(IVL_DIV), .SAR_DIV(SAR_DIV), .TRK_DIV(TRK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .tick_o(tick_w)
  );

  dllc_seq #(.CODE_W(CODE_W), .IVL_BITS(IVL_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .cmp_i(cmp_i),
    .code_o(code_w), .mode_o(mode_w), .locked_o(locked_o)
  );

  dllc_therm #(.IN_W(HALF_W)) u_crs (
    .val_i(code_w[CODE_W-1:HALF_W]), .therm_o(crs_therm_o), .therm_n_o(crs_therm_n_o)
  );

  dllc_therm #(.IN_W(HALF_W)) u_fin (
    .val_i(code_w[HALF_W-1:0]), .therm_o(fin_therm_o), .therm_n_o(fin_therm_n_o)
  );

  assign code_o = code_w;
  assign mode_o = mode_w;

  // R2: thermometer population matches each code half
  a_r2_coarse_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(crs_therm_o) == int'(code_w[CODE_W-1:HALF_W]));
  a_r2_fine_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fin_therm_o) == int'(code_w[HALF_W-1:0]));
  a_r2_compl: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_therm_n_o == ~crs_therm_o) && (fin_therm_n_o == ~fin_therm_o));
endmodule

// File: tb/tb_dll_code_ctrl.sv
`timescale 1ns/1ps
module tb_dll_code_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_i = 1'b0;
  logic [9:0]  code_o;
  logic [31:0] crs_therm_o, crs_therm_n_o, fin_therm_o, fin_therm_n_o;
  logic [1:0]  mode_o;
  logic        locked_o;

  always #4 clk = ~clk;

  dll_code_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .code_o(code_o),
    .crs_therm_o(crs_therm_o), .crs_therm_n_o(crs_therm_n_o),
    .fin_therm_o(fin_therm_o), .fin_therm_n_o(fin_therm_n_o),
    .mode_o(mode_o), .locked_o(locked_o)
  );

  int total = 0;
  int bad = 0;
  int tgt = 0;
  int edge_n = 0;
  bit force_low = 1'b0;

  localparam int VEC_N = 8;
  localparam int VT[VEC_N] = '{0, 100, 128, 500, 721, 895, 896, 1023};
  localparam int VL[VEC_N] = '{64, 64, 68, 76, 84, 88, 88, 88};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_cmp();
    cmp_i = force_low ? 1'b0 : (int'(code_o) <= tgt);
  endtask

  task automatic step();
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    drive_cmp();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    force_low = 1'b0;
    repeat (2) @(negedge clk);
    chk(code_o == 10'd64 && mode_o == 2'd0 && locked_o == 1'b0, "R1 in reset", int'(code_o), 64);
    rst_n = 1'b1;
    edge_n = 0;
    drive_cmp();
  endtask

  task automatic chk_therm(input string req);
    logic [31:0] ec, ef;
    for (int i = 0; i < 32; i++) begin
      ec[i] = (i < int'(code_o[9:5]));
      ef[i] = (i < int'(code_o[4:0]));
    end
    chk(crs_therm_o == ec && fin_therm_o == ef && crs_therm_n_o == ~ec && fin_therm_n_o == ~ef,
        req, int'(code_o), int'(code_o));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // table walk: target, expected lock edge
    for (int v = 0; v < VEC_N; v++) begin
      int lock_at;
      int lock_code;
      tgt = VT[v];
      do_reset();
      chk(code_o == 10'd64 && mode_o == 2'd0 && locked_o == 1'b0, "R1 after release", int'(code_o), 64);
      chk_therm("R2 reset code");
      lock_at = -1;
      lock_code = -1;
      for (int e = 1; e <= 100; e++) begin
        step();
        if (edge_n == 3) chk(code_o == 10'd64, "R4 no early update", int'(code_o), 64);
        if (edge_n == 4) chk(code_o == 10'd128, "R3 forced first step", int'(code_o), 128);
        if (edge_n == 8 && tgt >= 128) chk(code_o == 10'd256, "R4 interval advance", int'(code_o), 256);
        if (edge_n == 8 && tgt < 128) chk(code_o == 10'd64 && mode_o == 2'd1, "R5 exit from 2nd interval", int'(code_o), 64);
        if (locked_o && lock_at < 0) begin
          lock_at = edge_n;
          lock_code = int'(code_o);
          chk_therm("R2 lock code");
        end
      end
      chk(lock_at == VL[v], "R7 lock edge", lock_at, VL[v]);
      chk(lock_code == tgt, "R6 search result", lock_code, tgt);
      if (tgt == 1023)
        chk(code_o == 10'd1023 && mode_o == 2'd2, "R8 high saturation", int'(code_o), 1023);
      else
        chk((int'(code_o) == tgt || int'(code_o) == tgt + 1) && mode_o == 2'd2, "R8 tracking",
            int'(code_o), tgt);
    end

    // R5 / R6 detail at target 721
    tgt = 721;
    do_reset();
    while (edge_n < 28) step();
    chk(code_o == 10'd704 && mode_o == 2'd1, "R5 step back to lower interval", int'(code_o), 704);
    while (edge_n < 35) step();
    chk(code_o == 10'd704, "R6 hold between search updates", int'(code_o), 704);
    step();
    chk(code_o == 10'd736, "R6 keep bit6 then trial bit5", int'(code_o), 736);

    // R5 top interval with compare high
    tgt = 1023;
    do_reset();
    while (edge_n < 32) step();
    chk(code_o == 10'd960 && mode_o == 2'd1, "R5 top interval entry", int'(code_o), 960);

    // R8 low saturation and R9 sticky lock
    tgt = 3;
    do_reset();
    while (edge_n < 100) step();
    force_low = 1'b1;
    drive_cmp();
    for (int e = 0; e < 80; e++) step();
    chk(code_o == 10'd0 && mode_o == 2'd2, "R8 low saturation", int'(code_o), 0);
    chk(locked_o == 1'b1, "R9 lock held", int'(locked_o), 1);
    force_low = 1'b0;
    tgt = 1023;
    for (int e = 0; e < 24; e++) step();
    chk(code_o == 10'd3, "R8 one step per update", int'(code_o), 3);

    // R1 reset from tracking
    do_reset();
    chk(code_o == 10'd64 && locked_o == 1'b0 && mode_o == 2'd0, "R1 reset from tracking", int'(code_o), 64);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule